// File: doc/BRIEF.md
# SPI Command-Byte Register Port

This block is the serial front end of a peripheral controller's register file. An external SPI master lowers chip select and first sends a command byte. The command byte names one of 32 registers, sets the transfer direction and carries a handshake-status bit. Any number of data bytes follow. The block turns this serial traffic into single-cycle strobes for the local logic: register writes, register reads, FIFO pushes and FIFO pops. It also gives a one-cycle pulse that writes the status bit into the endpoint stall register.

The address taken from the command byte is held until chip select rises, so a master can stream a FIFO in one transaction. A parameter bitmap marks which addresses are FIFOs. A non-FIFO address is rewritten or reread by each data byte. SCK, chip select and MOSI are resampled in the system clock domain. Data is taken on rising SCK and MISO moves on falling SCK. Because of this, an idle-low clock (mode 0,0) and an idle-high clock (mode 1,1) both work with no mode input.

Top module: `spi_cmd_port`

## Requirements
- R1: Every byte is shifted most significant bit first, in both directions.
- R2: Command byte decode: bits 7:3 are the register address, bit 1 is the direction (1 = write, 0 = read) and bit 0 is the status bit. Bit 2 has no effect on any output.
- R3: Every completed command byte produces one single-cycle `stall_wr_o` pulse, with `stall_val_o` equal to command bit 0.
- R4: In a write to a non-FIFO address, each completed data byte gives one `reg_wr_o` pulse. That pulse carries the command's address on `addr_o` and the byte on `wr_data_o`. Later bytes in the same transaction target the same address.
- R5: In a write to a FIFO address (bitmap bit set; the default map makes addresses 0 and 1 FIFOs), each data byte gives one `fifo_push_o`. Command 0x02 followed by 37 bytes gives exactly 37 pushes, in order, and no register writes.
- R6: In a read, the first fetch is issued when the command byte completes, so the first data byte's MSB is on MISO before the first data rising edge. A further fetch follows the last bit of every data byte. Non-FIFO addresses use `reg_rd_o`, and each read of such an address returns the same register. FIFO addresses use `fifo_pop_o`. A read of N bytes makes N+1 fetches.
- R7: Idle-low SCK (mode 0,0) and idle-high SCK (mode 1,1) give the same strobes and the same MISO bytes. There is no configuration input.
- R8: Chip select high ends the transaction. A partial byte produces no strobe. The first byte after the next falling chip select is decoded as a command.
- R9: `spi_miso_oe` is low while chip select is high and during every command byte. While it is low, `spi_miso` is 0.
- R10: In reset, all strobes and `spi_miso_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out (0 when not enabled) |
| spi_miso_oe | output | 1 | Output enable for the MISO pad |
| addr_o | output | 5 | Register address held from the command byte |
| wr_data_o | output | 8 | Received data byte for writes and pushes |
| reg_wr_o | output | 1 | Register write strobe |
| fifo_push_o | output | 1 | FIFO push strobe |
| reg_rd_o | output | 1 | Register read request; `rd_data_i` is taken in the same cycle |
| fifo_pop_o | output | 1 | FIFO pop request; `rd_data_i` is taken in the same cycle |
| rd_data_i | input | 8 | Read data returned by the local logic |
| stall_wr_o | output | 1 | One-cycle pulse that writes the stall register bit |
| stall_val_o | output | 1 | Value for the stall register bit |

## Verification
A strobe appears about four system clocks after the SCK rising edge that completes its byte: two synchronizer stages, one edge-detect flop and the state register. A fetched byte is loaded into the MISO shifter one clock after its strobe. MISO moves about four clocks after a falling SCK. The bench holds each SCK half period for eight system clocks, so every result is settled well before the next edge. It samples MISO at the instant it raises SCK. It compares strobe counters and logged write data only after chip select has risen and 32 further clocks have passed.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 5;
    localparam int CNT_W    = $clog2(BYTE_W);
    localparam int NREGS    = 1 << ADDR_W;
    localparam int ADDR_LSB = BYTE_W - ADDR_W;
    localparam int DIR_BIT  = 1;
    localparam int STS_BIT  = 0;

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] stage_d;
        if (g == 0) begin : g_first
            assign stage_d = async_i;
        end else begin : g_next
            assign stage_d = stage_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_cmd_txshift.sv
module spi_cmd_txshift
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              shift_i,
    output logic              msb_o
);
    logic [BYTE_W-1:0] tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (load_i)       tx_d = data_i;
        else if (shift_i) tx_d = {tx_q[BYTE_W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign msb_o = tx_q[BYTE_W-1];

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !shift_i) |=> $stable(tx_q)); // R1
endmodule

// File: rtl/spi_cmd_core.sv
module spi_cmd_core
    import spi_cmd_pkg::*;
#(
    parameter logic [NREGS-1:0] FIFO_MAP = 32'h0000_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act_i,
    input  logic              sck_rise_i,
    input  logic              sck_fall_i,
    input  logic              mosi_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              reg_wr_o,
    output logic              push_o,
    output logic              reg_rd_o,
    output logic              pop_o,
    output logic              stall_o,
    output logic              stall_val_o,
    output logic              shift_o,
    output logic              oe_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  bit_cnt;
        phase_e            phase;
        logic [BYTE_W-1:0] rx;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              fifo;
        logic [BYTE_W-1:0] wdata;
        logic              reg_wr;
        logic              push;
        logic              reg_rd;
        logic              pop;
        logic              stall;
        logic              stall_val;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [BYTE_W-1:0] rx_n;
    logic [ADDR_W-1:0] cmd_addr;
    logic              cmd_fifo;

    assign rx_n     = {st_q.rx[BYTE_W-2:0], mosi_i};
    assign cmd_addr = rx_n[BYTE_W-1:ADDR_LSB];
    assign cmd_fifo = FIFO_MAP[cmd_addr];

    always_comb begin
        st_d        = st_q;
        st_d.reg_wr = 1'b0;
        st_d.push   = 1'b0;
        st_d.reg_rd = 1'b0;
        st_d.pop    = 1'b0;
        st_d.stall  = 1'b0;
        if (!cs_act_i) begin
            st_d.bit_cnt = '0;
            st_d.phase   = PH_CMD;
            st_d.rx      = '0;
        end else if (sck_rise_i) begin
            st_d.rx      = rx_n;
            st_d.bit_cnt = st_q.bit_cnt + 1'b1;
            if (st_q.bit_cnt == LAST_BIT) begin
                st_d.bit_cnt = '0;
                if (st_q.phase == PH_CMD) begin
                    st_d.phase     = PH_DATA;
                    st_d.addr      = cmd_addr;
                    st_d.wr        = rx_n[DIR_BIT];
                    st_d.fifo      = cmd_fifo;
                    st_d.stall     = 1'b1;
                    st_d.stall_val = rx_n[STS_BIT];
                    st_d.reg_rd    = !rx_n[DIR_BIT] && !cmd_fifo;
                    st_d.pop       = !rx_n[DIR_BIT] && cmd_fifo;
                end else if (st_q.wr) begin
                    st_d.wdata  = rx_n;
                    st_d.reg_wr = !st_q.fifo;
                    st_d.push   = st_q.fifo;
                end else begin
                    st_d.reg_rd = !st_q.fifo;
                    st_d.pop    = st_q.fifo;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_CMD;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o      = st_q.addr;
    assign wr_data_o   = st_q.wdata;
    assign reg_wr_o    = st_q.reg_wr;
    assign push_o      = st_q.push;
    assign reg_rd_o    = st_q.reg_rd;
    assign pop_o       = st_q.pop;
    assign stall_o     = st_q.stall;
    assign stall_val_o = st_q.stall_val;
    assign shift_o     = sck_fall_i && cs_act_i && (st_q.phase == PH_DATA) && (st_q.bit_cnt != '0);
    assign oe_o        = cs_act_i && (st_q.phase == PH_DATA) && !st_q.wr;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.reg_wr, st_q.push, st_q.reg_rd, st_q.pop})); // R4
    AST_STALL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stall |=> !st_q.stall); // R3
    AST_PARTIAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act_i |=> !(st_q.reg_wr || st_q.push)); // R8
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act_i |=> (st_q.bit_cnt == '0)); // R8
    AST_OE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_o) |-> st_q.stall); // R9
endmodule

// File: rtl/spi_cmd_port.sv
module spi_cmd_port
    import spi_cmd_pkg::*;
#(
    parameter logic [NREGS-1:0] FIFO_MAP    = 32'h0000_0003,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              reg_wr_o,
    output logic              fifo_push_o,
    output logic              reg_rd_o,
    output logic              fifo_pop_o,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              stall_wr_o,
    output logic              stall_val_o
);
    logic [2:0] pins_s;
    logic       sck_prev_q;
    logic       sck_rise, sck_fall, cs_act;
    logic       shift, oe, tx_msb;

    spi_cmd_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({spi_cs_n, spi_sck, spi_mosi}),
        .sync_o (pins_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev_q <= 1'b0;
        else        sck_prev_q <= pins_s[1];
    end

    assign cs_act   = !pins_s[2];
    assign sck_rise = pins_s[1] && !sck_prev_q;
    assign sck_fall = !pins_s[1] && sck_prev_q;

    spi_cmd_core #(
        .FIFO_MAP(FIFO_MAP)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_act_i   (cs_act),
        .sck_rise_i (sck_rise),
        .sck_fall_i (sck_fall),
        .mosi_i     (pins_s[0]),
        .addr_o     (addr_o),
        .wr_data_o  (wr_data_o),
        .reg_wr_o   (reg_wr_o),
        .push_o     (fifo_push_o),
        .reg_rd_o   (reg_rd_o),
        .pop_o      (fifo_pop_o),
        .stall_o    (stall_wr_o),
        .stall_val_o(stall_val_o),
        .shift_o    (shift),
        .oe_o       (oe)
    );

    spi_cmd_txshift u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (reg_rd_o || fifo_pop_o),
        .data_i (rd_data_i),
        .shift_i(shift),
        .msb_o  (tx_msb)
    );

    assign spi_miso_oe = oe;
    assign spi_miso    = oe ? tx_msb : 1'b0;
endmodule

// File: tb/spi_cmd_port_tb.sv
`timescale 1ns/1ps
module spi_cmd_port_tb;
    localparam int HALF = 8;
    localparam int NV   = 8;
    localparam logic [31:0] FMAP = 32'h0000_0003;
    // {mode, command, data0, data1}
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 8'h2A, 8'h3C, 8'hC3},
        {1'b1, 8'h2A, 8'h81, 8'h7E},
        {1'b0, 8'h28, 8'h00, 8'h00},
        {1'b1, 8'h49, 8'hFF, 8'hFF},
        {1'b0, 8'h00, 8'h00, 8'h00},
        {1'b1, 8'h0B, 8'h55, 8'hAA},
        {1'b1, 8'h08, 8'h00, 8'h00},
        {1'b0, 8'hFB, 8'h01, 8'h80}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, oe;
    logic [4:0] addr;
    logic [7:0] wdata, rdata;
    logic reg_wr, push, reg_rd, pop, stall, stall_val;

    int nwr = 0, npush = 0, nrd = 0, npop = 0, nstall = 0, wcnt = 0;
    logic stall_last = 1'b0;
    logic [4:0] wl_addr [64];
    logic [7:0] wl_data [64];
    logic       wl_push [64];

    assign rdata = pop ? (8'hA0 + npop[7:0]) : {3'b110, addr};

    spi_cmd_port #(.FIFO_MAP(FMAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(oe), .addr_o(addr), .wr_data_o(wdata),
        .reg_wr_o(reg_wr), .fifo_push_o(push), .reg_rd_o(reg_rd), .fifo_pop_o(pop),
        .rd_data_i(rdata), .stall_wr_o(stall), .stall_val_o(stall_val)
    );

    always @(posedge clk) begin
        if (reg_wr || push) begin
            wl_addr[wcnt % 64] <= addr;
            wl_data[wcnt % 64] <= wdata;
            wl_push[wcnt % 64] <= push;
            wcnt <= wcnt + 1;
        end
        if (reg_wr) nwr <= nwr + 1;
        if (push)   npush <= npush + 1;
        if (reg_rd) nrd <= nrd + 1;
        if (pop)    npop <= npop + 1;
        if (stall) begin
            nstall <= nstall + 1;
            stall_last <= stall_val;
        end
    end

    int checks = 0, errors = 0;
    bit done = 0;
    logic mode = 1'b0;
    logic oe_any = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bit(input logic b, output logic r);
        if (mode) sck = 1'b0;
        mosi = b;
        wait_clk(HALF);
        r = miso;
        oe_any = oe_any | oe;
        sck = 1'b1;
        wait_clk(HALF);
        if (!mode) sck = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] o, output logic [7:0] i);
        logic [7:0] v;
        logic rb;
        for (int k = 7; k >= 0; k--) begin
            spi_bit(o[k], rb);
            v[k] = rb;
        end
        i = v;
    endtask

    task automatic cs_begin(input logic m);
        mode = m;
        sck = m;
        wait_clk(HALF);
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_end;
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(4 * HALF);
    endtask

    initial begin
        wait_clk(150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx, r0, r1, rc;
        int bw, bp, br, bpop, bs, bwc, bad;
        wait_clk(5);
        // R10: reset state
        chk(!(reg_wr || push || reg_rd || pop || stall) && !oe, "R10", "strobes in reset",
            {reg_wr, push, reg_rd, pop, stall, oe}, 0);
        rst_n = 1'b1;
        wait_clk(10);
        chk(!(reg_wr || push || reg_rd || pop || stall) && !oe, "R10", "strobes after reset",
            {reg_wr, push, reg_rd, pop, stall, oe}, 0);

        for (int v = 0; v < NV; v++) begin
            logic m, f, w;
            logic [7:0] c, d0, d1, e0, e1;
            logic [4:0] a;
            {m, c, d0, d1} = VEC[v];
            a = c[7:3];
            f = FMAP[a];
            w = c[1];
            bw = nwr; bp = npush; br = nrd; bpop = npop; bs = nstall; bwc = wcnt;
            cs_begin(m);
            oe_any = 1'b0;
            spi_byte(c, rc);
            chk(!oe_any, "R9", "oe during command", oe_any, 0);
            spi_byte(d0, r0);
            spi_byte(d1, r1);
            cs_end();
            chk(!oe && !miso, "R9", "miso idle", {oe, miso}, 0);
            chk(nstall == bs + 1 && stall_last == c[0], "R3", "stall pulse/value",
                {nstall - bs, 3'b0, stall_last}, {1, 3'b0, c[0]});
            if (w) begin
                chk((f ? npush - bp : nwr - bw) == 2 && (f ? nwr - bw : npush - bp) == 0,
                    f ? "R5" : "R4", "write strobe count", f ? npush - bp : nwr - bw, 2);
                chk(wl_addr[bwc % 64] == a && wl_addr[(bwc + 1) % 64] == a &&
                    wl_push[bwc % 64] == f && wl_push[(bwc + 1) % 64] == f,
                    "R4", "write address held", wl_addr[(bwc + 1) % 64], a);
                chk(wl_data[bwc % 64] == d0 && wl_data[(bwc + 1) % 64] == d1, "R7",
                    "write data by mode", {wl_data[bwc % 64], wl_data[(bwc + 1) % 64]}, {d0, d1});
            end else begin
                e0 = f ? 8'hA0 + bpop[7:0] : {3'b110, a};
                e1 = f ? 8'hA1 + bpop[7:0] : {3'b110, a};
                chk((f ? npop - bpop : nrd - br) == 3, "R6", "fetch count",
                    f ? npop - bpop : nrd - br, 3);
                chk(r0 == e0 && r1 == e1, "R1", "MISO bytes msb first", {r0, r1}, {e0, e1});
                chk(nwr == bw && npush == bp, "R6", "no write on read", nwr - bw, 0);
            end
        end

        // R5: 37-byte FIFO burst with command 0x02
        bp = npush; bw = nwr; bwc = wcnt; bad = 0;
        cs_begin(1'b0);
        spi_byte(8'h02, rc);
        for (int i = 0; i < 37; i++) spi_byte(8'(i * 7 + 3), rx);
        cs_end();
        chk(npush - bp == 37 && nwr == bw, "R5", "burst push count", npush - bp, 37);
        for (int i = 0; i < 37; i++)
            if (wl_data[(bwc + i) % 64] != 8'(i * 7 + 3) || !wl_push[(bwc + i) % 64] ||
                wl_addr[(bwc + i) % 64] != 5'd0) bad++;
        chk(bad == 0, "R5", "burst data order", bad, 0);

        // R2: bit 2 set has no effect
        bw = nwr; bwc = wcnt; bs = nstall;
        cs_begin(1'b0);
        spi_byte(8'h2E, rc);
        spi_byte(8'h99, rx);
        cs_end();
        chk(nwr - bw == 1 && wl_addr[bwc % 64] == 5'd5 && wl_data[bwc % 64] == 8'h99 &&
            !wl_push[bwc % 64], "R2", "bit2 ignored", wl_data[bwc % 64], 8'h99);
        chk(nstall - bs == 1 && stall_last == 1'b0, "R3", "stall value zero", stall_last, 0);

        // R8: partial byte dropped, next transaction starts with a command
        bw = nwr; bp = npush; bwc = wcnt;
        cs_begin(1'b1);
        spi_byte(8'h2A, rc);
        spi_byte(8'h11, rx);
        for (int k = 0; k < 5; k++) spi_bit(1'b1, rc[0]);
        cs_end();
        chk(nwr - bw == 1 && npush == bp && wl_data[bwc % 64] == 8'h11, "R8",
            "partial byte discarded", nwr - bw, 1);
        cs_begin(1'b1);
        spi_byte(8'h30, rc);
        spi_byte(8'h00, rx);
        cs_end();
        chk(rx == 8'hC6, "R8", "new command after cs", rx, 8'hC6);
        chk(!oe, "R9", "oe low with cs high", oe, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule